// File: doc/BRIEF.md
# Host Control Endpoint Sequencer

This block holds the control and status byte for the control endpoint (endpoint 0) of a USB host controller and sequences its transactions. Software writes a byte through a plain register port to ask for a transaction. The block then requests a token from a packet engine (SETUP, OUT or IN) together with the data toggle to use. It takes back one result code per attempt and updates its status bits. It also counts missing responses and the time spent receiving NAKs, and pulses an interrupt flag when something software must look at has happened.

Writes have side effects. A SETUP request forces the toggle to DATA0 and a status-stage request forces it to DATA1. Request bits clear themselves when the transaction ends, and the sticky status bits are cleared by writing 0 to them. A long run of NAKs halts the endpoint until software releases it. A missing response on three attempts in a row ends the request with an error.

Top module: `usb_ep0_seq`

## Requirements
- R1: After reset, reg_rdata_o is 0x00, tok_req_o is 0, irq_o is 0 and tok_pid1_o is 0.
- R2: Register bits are: 7 nak_halt, 6 status_stage, 5 in_req, 4 err, 3 setup_tok, 2 stalled, 1 tx_req, 0 rx_full. While tx_req or in_req is set and nak_halt is clear, tok_req_o is 1. tok_kind_o is 1 (SETUP) when tx_req and setup_tok are set, 0 (OUT) when tx_req alone is set, and 2 (IN) when only in_req is set. tx_req takes priority over in_req.
- R3: A write with tx_req=1 and setup_tok=1 sets the toggle to 0. A write with status_stage=1 and tx_req or in_req set sets the toggle to 1. A write override takes priority over a toggle flip in the same cycle.
- R4: The toggle (tok_pid1_o) flips on a completed OUT/SETUP (result ACK) and on a completed IN (result DATA). It does not flip on NAK, STALL or no response.
- R5: The result code ACK (0) on an OUT/SETUP attempt clears tx_req, setup_tok and status_stage. irq_o pulses for one cycle at the same clock edge.
- R6: The result code DATA (4) on an IN attempt sets rx_full and clears in_req and status_stage, with a one-cycle irq_o pulse. rx_full stays set until software clears it.
- R7: The result code NORESP (3) on three consecutive attempts sets err, clears the request bits and pulses irq_o. Any other result or a new request write restarts the count.
- R8: The result code STALL (2) sets stalled, clears the request bits and pulses irq_o.
- R9: After a NAK result (1), once nak_limit_i frame-start pulses arrive with no other result, nak_halt is set, irq_o pulses and tok_req_o drops until software clears nak_halt. A nak_limit_i of 0 disables the halt.
- R10: Writing 0 clears err, stalled, rx_full and nak_halt, and writing 1 to them has no effect. A hardware set in the same cycle as a clearing write wins.
- R11: A result presented while tok_req_o is 0 is ignored. No bit changes and irq_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| sof_i | input | 1 | Frame-start pulse |
| nak_limit_i | input | NAK_W | NAK limit in frames, 0 disables |
| tok_req_o | output | 1 | Token request to the packet engine |
| tok_kind_o | output | 2 | 0 OUT, 1 SETUP, 2 IN |
| tok_pid1_o | output | 1 | Data toggle: 1 selects DATA1 |
| res_valid_i | input | 1 | Result strobe from the engine |
| res_code_i | input | 3 | 0 ACK, 1 NAK, 2 STALL, 3 NORESP, 4 DATA |
| irq_o | output | 1 | Endpoint-0 interrupt pulse |

## Verification
The sequencer is driven through a full control transfer (SETUP, OUT data, IN status with a forced DATA1), so the token kind and the toggle can be followed across stages and overrides can be told apart from natural flips. Runs of missing responses broken by a NAK show whether the retry count restarts correctly. NAK runs counted against frame pulses, with a non-zero limit and with a zero limit, separate the halt from the disable case. A clearing write in the same cycle as an incoming DATA result, and results presented while idle, show which of two simultaneous events wins and that stray results have no effect.

// File: rtl/usb_ep0_pkg.sv
package usb_ep0_pkg;
  typedef enum logic [1:0] {TOK_OUT = 2'd0, TOK_SETUP = 2'd1, TOK_IN = 2'd2} tok_kind_e;
  typedef enum logic [2:0] {
    RES_ACK = 3'd0, RES_NAK = 3'd1, RES_STALL = 3'd2, RES_NORESP = 3'd3, RES_DATA = 3'd4
  } res_code_e;
  localparam int unsigned B_RXF  = 0;
  localparam int unsigned B_TXR  = 1;
  localparam int unsigned B_STL  = 2;
  localparam int unsigned B_SET  = 3;
  localparam int unsigned B_ERR  = 4;
  localparam int unsigned B_INR  = 5;
  localparam int unsigned B_STS  = 6;
  localparam int unsigned B_NAKH = 7;
endpackage

// File: rtl/ep0_retry_ctr.sv
module ep0_retry_ctr #(
  parameter int unsigned MAX_TRIES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic miss_i,
  input  logic clr_i,
  output logic fail_o
);
  localparam int unsigned CW = $clog2(MAX_TRIES + 1);
  logic [CW-1:0] cnt_q;

  assign fail_o = miss_i && !clr_i && (cnt_q == CW'(MAX_TRIES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || fail_o)   cnt_q <= '0;
    else if (miss_i)            cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/ep0_nak_timer.sv
module ep0_nak_timer #(
  parameter int unsigned NAK_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nak_i,
  input  logic             clr_i,
  input  logic             sof_i,
  input  logic             run_en_i,
  input  logic [NAK_W-1:0] limit_i,
  output logic             expire_o
);
  logic             run_q;
  logic [NAK_W-1:0] cnt_q;
  logic             tick;

  assign tick     = sof_i && run_q && run_en_i && (limit_i != '0);
  assign expire_o = tick && !clr_i && (cnt_q == limit_i - NAK_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i || expire_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (nak_i) run_q <= 1'b1;
      if (tick)  cnt_q <= cnt_q + NAK_W'(1);
    end
  end
endmodule

// File: rtl/usb_ep0_seq.sv
module usb_ep0_seq
  import usb_ep0_pkg::*;
#(
  parameter int unsigned NAK_W     = 8,
  parameter int unsigned MAX_TRIES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             sof_i,
  input  logic [NAK_W-1:0] nak_limit_i,
  output logic             tok_req_o,
  output logic [1:0]       tok_kind_o,
  output logic             tok_pid1_o,
  input  logic             res_valid_i,
  input  logic [2:0]       res_code_i,
  output logic             irq_o
);
  logic tx_q, in_q, set_q, sts_q, err_q, stl_q, rxf_q, nakh_q, tog_q, irq_q;
  logic active, res_ok, ack_done, rx_done, nak_evt, stall_evt, miss_evt;
  logic err_evt, nakh_evt, req_wr, setup_wr, sts_wr, end_tx, end_in;
  res_code_e res;

  assign res      = res_code_e'(res_code_i);
  assign active   = (tx_q || in_q) && !nakh_q;
  assign res_ok   = res_valid_i && active;
  assign ack_done = res_ok && tx_q  && (res == RES_ACK);
  assign rx_done  = res_ok && !tx_q && (res == RES_DATA);
  assign nak_evt  = res_ok && (res == RES_NAK);
  assign stall_evt= res_ok && (res == RES_STALL);
  assign miss_evt = res_ok && (res == RES_NORESP);

  assign req_wr   = reg_wr_i && (reg_wdata_i[B_TXR] || reg_wdata_i[B_INR]);
  assign setup_wr = reg_wr_i && reg_wdata_i[B_TXR] && reg_wdata_i[B_SET];
  assign sts_wr   = req_wr && reg_wdata_i[B_STS];
  assign end_tx   = ack_done || stall_evt || err_evt;
  assign end_in   = rx_done  || stall_evt || err_evt;

  ep0_retry_ctr #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .miss_i (miss_evt),
    .clr_i  (req_wr || (res_ok && res != RES_NORESP)),
    .fail_o (err_evt)
  );

  ep0_nak_timer #(.NAK_W(NAK_W)) u_nak (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .nak_i    (nak_evt),
    .clr_i    (req_wr || (res_ok && res != RES_NAK) ||
               (nakh_q && reg_wr_i && !reg_wdata_i[B_NAKH])),
    .sof_i    (sof_i),
    .run_en_i (active),
    .limit_i  (nak_limit_i),
    .expire_o (nakh_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {tx_q, in_q, set_q, sts_q, err_q, stl_q, rxf_q, nakh_q, tog_q, irq_q} <= '0;
    end else begin
      // request bits: a write sets them and wins over a hardware end
      if (reg_wr_i && reg_wdata_i[B_TXR]) tx_q <= 1'b1;
      else if (end_tx)                    tx_q <= 1'b0;
      if (reg_wr_i && reg_wdata_i[B_INR]) in_q <= 1'b1;
      else if (end_in)                    in_q <= 1'b0;
      if (reg_wr_i && reg_wdata_i[B_TXR]) set_q <= reg_wdata_i[B_SET];
      else if (end_tx)                    set_q <= 1'b0;
      if (req_wr)                         sts_q <= reg_wdata_i[B_STS];
      else if (ack_done || rx_done || stall_evt || err_evt) sts_q <= 1'b0;
      // sticky bits: hardware set beats a clearing write
      if (err_evt)                                err_q <= 1'b1;
      else if (reg_wr_i && !reg_wdata_i[B_ERR])   err_q <= 1'b0;
      if (stall_evt)                              stl_q <= 1'b1;
      else if (reg_wr_i && !reg_wdata_i[B_STL])   stl_q <= 1'b0;
      if (rx_done)                                rxf_q <= 1'b1;
      else if (reg_wr_i && !reg_wdata_i[B_RXF])   rxf_q <= 1'b0;
      if (nakh_evt)                               nakh_q <= 1'b1;
      else if (reg_wr_i && !reg_wdata_i[B_NAKH])  nakh_q <= 1'b0;
      if (setup_wr)                   tog_q <= 1'b0;
      else if (sts_wr)                tog_q <= 1'b1;
      else if (ack_done || rx_done)   tog_q <= ~tog_q;
      irq_q <= ack_done || rx_done || err_evt || stall_evt || nakh_evt;
    end
  end

  always_comb begin
    reg_rdata_o          = '0;
    reg_rdata_o[B_NAKH]  = nakh_q;
    reg_rdata_o[B_STS]   = sts_q;
    reg_rdata_o[B_INR]   = in_q;
    reg_rdata_o[B_ERR]   = err_q;
    reg_rdata_o[B_SET]   = set_q;
    reg_rdata_o[B_STL]   = stl_q;
    reg_rdata_o[B_TXR]   = tx_q;
    reg_rdata_o[B_RXF]   = rxf_q;
  end

  assign tok_req_o  = active;
  assign tok_kind_o = !tx_q ? TOK_IN : (set_q ? TOK_SETUP : TOK_OUT);
  assign tok_pid1_o = tog_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/usb_ep0_seq_chk.sv
module usb_ep0_seq_chk #(
  parameter int unsigned NAK_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [7:0]       reg_rdata_o,
  input logic             tok_req_o,
  input logic [1:0]       tok_kind_o,
  input logic             tok_pid1_o,
  input logic             res_valid_i,
  input logic [2:0]       res_code_i,
  input logic             irq_o
);
  assert_kind_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_req_o |-> tok_kind_o != 2'd3);
  assert_req_matches_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_req_o == ((reg_rdata_o[1] || reg_rdata_o[5]) && !reg_rdata_o[7]));
  assert_ack_ends_tx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && tok_req_o && res_code_i == 3'd0 && tok_kind_o != 2'd2 && !reg_wr_i)
    |=> (irq_o && !reg_rdata_o[1]));
  assert_data_fills_rx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && tok_req_o && res_code_i == 3'd4 && tok_kind_o == 2'd2)
    |=> (irq_o && reg_rdata_o[0]));
  assert_toggle_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && tok_req_o && !reg_wr_i &&
     ((res_code_i == 3'd0 && tok_kind_o != 2'd2) || (res_code_i == 3'd4 && tok_kind_o == 2'd2)))
    |=> tok_pid1_o != $past(tok_pid1_o));
  assert_halt_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7] |-> !tok_req_o);
  assert_idle_no_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_req_o |=> !irq_o);
  assert_stall_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && tok_req_o && res_code_i == 3'd2) |=> (reg_rdata_o[2] && irq_o && !tok_req_o));
endmodule

bind usb_ep0_seq usb_ep0_seq_chk #(.NAK_W(NAK_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_rdata_o (reg_rdata_o),
  .tok_req_o   (tok_req_o),
  .tok_kind_o  (tok_kind_o),
  .tok_pid1_o  (tok_pid1_o),
  .res_valid_i (res_valid_i),
  .res_code_i  (res_code_i),
  .irq_o       (irq_o)
);

// File: tb/usb_ep0_seq_tb_top.sv
`timescale 1ns/1ps
module usb_ep0_seq_tb_top;
  localparam int unsigned NAK_W = 8;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_wr_i = 1'b0, sof_i = 1'b0, res_valid_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [NAK_W-1:0] nak_limit_i = '0;
  logic [2:0] res_code_i = '0;
  logic [7:0] reg_rdata_o;
  logic tok_req_o, tok_pid1_o, irq_o;
  logic [1:0] tok_kind_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  usb_ep0_seq #(.NAK_W(NAK_W), .MAX_TRIES(3)) dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i); reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i); reg_wr_i = 1'b0;
  endtask

  task automatic res(input logic [2:0] c);
    @(negedge clk_i); res_valid_i = 1'b1; res_code_i = c;
    @(negedge clk_i); res_valid_i = 1'b0;
  endtask

  task automatic sof();
    @(negedge clk_i); sof_i = 1'b1;
    @(negedge clk_i); sof_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata_o, 8'h00);
    chk("R1 req", tok_req_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 pid", tok_pid1_o, 0);
  endtask

  task automatic t_setup_out();
    wr(8'h0A);
    chk("R2 setup req", tok_req_o, 1);
    chk("R2 setup kind", tok_kind_o, 1);
    chk("R3 setup pid0", tok_pid1_o, 0);
    res(3'd0);
    chk("R5 ack clears", reg_rdata_o, 8'h00);
    chk("R5 ack irq", irq_o, 1);
    chk("R4 flip after setup", tok_pid1_o, 1);
    wr(8'h02);
    chk("R2 out kind", tok_kind_o, 0);
    chk("R4 out pid", tok_pid1_o, 1);
    res(3'd1);
    chk("R4 nak no flip", tok_pid1_o, 1);
    res(3'd0);
    chk("R4 flip after out", tok_pid1_o, 0);
  endtask

  task automatic t_in_status();
    wr(8'h60);
    chk("R2 in kind", tok_kind_o, 2);
    chk("R3 status pid1", tok_pid1_o, 1);
    res(3'd4);
    chk("R6 rx set", reg_rdata_o, 8'h01);
    chk("R6 irq", irq_o, 1);
    chk("R4 flip after in", tok_pid1_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R6 rx sticky", reg_rdata_o, 8'h01);
    wr(8'h00);
    chk("R10 rx cleared", reg_rdata_o, 8'h00);
  endtask

  task automatic t_priority_stall();
    wr(8'h22);
    chk("R2 tx priority", tok_kind_o, 0);
    res(3'd0);
    chk("R2 in after tx", tok_kind_o, 2);
    chk("R5 in left", reg_rdata_o, 8'h20);
    res(3'd2);
    chk("R8 stalled", reg_rdata_o, 8'h04);
    chk("R8 irq", irq_o, 1);
    chk("R8 req off", tok_req_o, 0);
    wr(8'h00);
    wr(8'h94);
    chk("R10 write1 no set", reg_rdata_o, 8'h00);
  endtask

  task automatic t_retry();
    wr(8'h02);
    res(3'd3); res(3'd3);
    chk("R7 two misses", reg_rdata_o, 8'h02);
    res(3'd1);
    res(3'd3); res(3'd3);
    chk("R7 restart after nak", reg_rdata_o, 8'h02);
    chk("R7 no irq yet", irq_o, 0);
    res(3'd3);
    chk("R7 err set", reg_rdata_o, 8'h10);
    chk("R7 irq", irq_o, 1);
    wr(8'h00);
    chk("R10 err cleared", reg_rdata_o, 8'h00);
  endtask

  task automatic t_nak_halt();
    nak_limit_i = 8'd3;
    wr(8'h20);
    res(3'd1);
    sof(); sof();
    chk("R9 before limit", reg_rdata_o, 8'h20);
    sof();
    chk("R9 halted", reg_rdata_o, 8'hA0);
    chk("R9 irq", irq_o, 1);
    chk("R9 req off", tok_req_o, 0);
    res(3'd4);
    chk("R11 ignored while halted", reg_rdata_o, 8'hA0);
    chk("R11 no irq", irq_o, 0);
    wr(8'h20);
    chk("R9 resumed", tok_req_o, 1);
    nak_limit_i = 8'd0;
    res(3'd1);
    repeat (5) sof();
    chk("R9 limit 0 disables", reg_rdata_o, 8'h20);
  endtask

  task automatic t_collide();
    // clearing write (rx_full=0, in_req=1) in same cycle as DATA
    @(negedge clk_i); reg_wr_i = 1'b1; reg_wdata_i = 8'h20; res_valid_i = 1'b1; res_code_i = 3'd4;
    @(negedge clk_i); reg_wr_i = 1'b0; res_valid_i = 1'b0;
    chk("R10 hw set wins", reg_rdata_o, 8'h21);
    res(3'd2);
    wr(8'h00);
    res(3'd0);
    chk("R11 idle result ignored", reg_rdata_o, 8'h00);
    chk("R11 idle no irq", irq_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_setup_out();
    t_in_status();
    t_priority_stall();
    t_retry();
    t_nak_halt();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule